// File: doc/BRIEF.md
# Sector Wear-Leveling Address Remapper

This block sits between a host and a sector-erasable flash array and turns every logical sector number into a physical sector number. Translation uses a table held in flops. After reset the block fills that table by reading one entry per logical sector from a reserved metadata region, through a simple request/acknowledge port. It keeps the host stalled until the table is complete. The byte offset inside a sector is not translated. Every physical address that the block produces lies in the user region.

The host reports each sector erase on a notify port. The block counts erases for each physical sector. A logical sector can be in the high-endurance pool, which is selected by a configuration mask. When such a sector's count rises above a programmable threshold, the block looks for the least-worn other sector in the pool and exchanges the physical targets of the two logical sectors. It then writes both changed table entries back to the metadata region and signals completion. Sectors outside the pool keep a fixed mapping. That bookkeeping runs alongside the slow erase, while translation stays single-cycle throughout.

Top module: `wl_remap`

## Requirements
- R1: From reset until the table load ends, `busy` is 1 and `tr_ready` is 0. The load issues metadata reads (`md_we`=0) at `md_addr` 0, 1, …, N-1 in that order, and each acknowledged read stores `md_rdata` as the physical sector of the logical sector at that address.
- R2: A translation request accepted at a clock edge (`tr_valid` and `tr_ready` both 1) gives `out_valid`=1 after that edge. At the same time, `out_addr` = {1'b0, table[logical sector], offset}, where the logical sector is `tr_addr[OW+SW-1:OW]` and the offset is `tr_addr[OW-1:0]`.
- R3: Bit PA_W-1 of `out_addr` (the metadata-region select) is always 0 when `out_valid` is 1.
- R4: Each accepted erase adds one to the count of the physical sector that the erased logical sector maps to. A swap starts only when the new count is strictly greater than `cfg_threshold` and the logical sector's bit in `cfg_pool` is 1.
- R5: The swap partner is the logical sector in `cfg_pool`, other than the trigger, whose physical sector has the lowest count. On a tie the lowest logical index wins. If no such sector exists, no swap occurs and no completion pulse is given.
- R6: A logical sector whose `cfg_pool` bit is 0 is never a swap source or a swap target, and its translation never changes.
- R7: Erase counts saturate at 2^CW-1 and do not wrap. The threshold comparison is made again after every erase.
- R8: After a swap the block writes (`md_we`=1) the trigger's new entry and then the partner's new entry. For each write, `md_addr` is the logical sector and `md_wdata` is its new physical sector. `swap_done` pulses for one cycle in the cycle after the second write is acknowledged.
- R9: An accepted erase is held in a single pending slot. `er_ready` is 0 while the slot is full, for example during a swap, and the held erase is processed once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_threshold | input | CW | Erase-count threshold |
| cfg_pool | input | N | High-endurance pool mask, one bit per logical sector |
| busy | output | 1 | Table load in progress |
| tr_valid | input | 1 | Translation request |
| tr_ready | output | 1 | Translation request can be accepted |
| tr_addr | input | SW+OW | Logical address: sector, then offset |
| out_valid | output | 1 | Translated address valid |
| out_addr | output | 1+SW+OW | Physical address: region bit, sector, offset |
| er_valid | input | 1 | Erase notification |
| er_ready | output | 1 | Pending slot free |
| er_sector | input | SW | Logical sector that was erased |
| md_req | output | 1 | Metadata access request |
| md_we | output | 1 | Metadata access is a write |
| md_addr | output | SW | Metadata entry index (logical sector) |
| md_wdata | output | SW | Metadata write data (physical sector) |
| md_ack | input | 1 | Metadata access acknowledge; read data valid |
| md_rdata | input | SW | Metadata read data |
| swap_done | output | 1 | One-cycle pulse when a swap is written back |

## Verification
A translation result appears one edge after acceptance, so the bench drives a request at a falling edge and reads `out_addr` at the next falling edge. An erase is captured at one edge and counted at the next. A swap then scans N cycles, updates the table in one more, and issues its two writes. The completion pulse follows the second acknowledge by exactly one cycle, and a monitor measures that gap on the falling edge. After each erase the bench waits well past that N+6-cycle window and then compares every logical sector's translation and the logged metadata writes with a bench-side model of counts and mapping.

// File: rtl/wl_pkg.sv
package wl_pkg;
    typedef enum logic [2:0] {
        ST_LOAD,
        ST_IDLE,
        ST_SCAN,
        ST_SWAP,
        ST_WR_A,
        ST_WR_B
    } wl_state_e;
endpackage

// File: rtl/wl_map_table.sv
module wl_map_table #(
    parameter int N  = 16,
    parameter int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_idx,
    input  logic [SW-1:0] ld_data,
    input  logic          sw_en,
    input  logic [SW-1:0] sw_a,
    input  logic [SW-1:0] sw_b,
    input  logic [SW-1:0] ra_idx,
    output logic [SW-1:0] ra_data,
    input  logic [SW-1:0] rb_idx,
    output logic [SW-1:0] rb_data,
    input  logic [SW-1:0] rc_idx,
    output logic [SW-1:0] rc_data
);
    logic [SW-1:0] tab_q [N];
    logic [SW-1:0] tab_d [N];

    always_comb begin
        tab_d = tab_q;
        if (ld_en) begin
            tab_d[ld_idx] = ld_data;
        end
        if (sw_en) begin
            tab_d[sw_a] = tab_q[sw_b];
            tab_d[sw_b] = tab_q[sw_a];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                tab_q[i] <= SW'(i);
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    assign ra_data = tab_q[ra_idx];
    assign rb_data = tab_q[rb_idx];
    assign rc_data = tab_q[rc_idx];
endmodule

// File: rtl/wl_wear_counters.sv
module wl_wear_counters #(
    parameter int N  = 16,
    parameter int SW = $clog2(N),
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_en,
    input  logic [SW-1:0] inc_idx,
    input  logic [SW-1:0] ra_idx,
    output logic [CW-1:0] ra_cnt,
    input  logic [SW-1:0] rb_idx,
    output logic [CW-1:0] rb_cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q [N];
    logic [CW-1:0] cnt_d [N];

    always_comb begin
        cnt_d = cnt_q;
        if (inc_en && (cnt_q[inc_idx] != CNT_MAX)) begin
            cnt_d[inc_idx] = cnt_q[inc_idx] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                cnt_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ra_cnt = cnt_q[ra_idx];
    assign rb_cnt = cnt_q[rb_idx];
endmodule

// File: rtl/wl_remap.sv
module wl_remap #(
    parameter int N  = 16,
    parameter int OW = 8,
    parameter int CW = 8,
    localparam int SW   = $clog2(N),
    localparam int LA_W = SW + OW,
    localparam int PA_W = 1 + SW + OW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   cfg_threshold,
    input  logic [N-1:0]    cfg_pool,
    output logic            busy,
    input  logic            tr_valid,
    output logic            tr_ready,
    input  logic [LA_W-1:0] tr_addr,
    output logic            out_valid,
    output logic [PA_W-1:0] out_addr,
    input  logic            er_valid,
    output logic            er_ready,
    input  logic [SW-1:0]   er_sector,
    output logic            md_req,
    output logic            md_we,
    output logic [SW-1:0]   md_addr,
    output logic [SW-1:0]   md_wdata,
    input  logic            md_ack,
    input  logic [SW-1:0]   md_rdata,
    output logic            swap_done
);
    import wl_pkg::*;

    localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
    localparam logic [SW-1:0] LAST_IDX = SW'(N - 1);

    typedef struct packed {
        wl_state_e       st;
        logic [SW-1:0]   idx;
        logic [SW-1:0]   trig;
        logic [SW-1:0]   best;
        logic [CW-1:0]   best_cnt;
        logic            found;
        logic            pend_v;
        logic [SW-1:0]   pend_sec;
        logic            done;
        logic            out_v;
        logic [PA_W-1:0] out_addr;
    } regs_t;

    regs_t r_q, r_d;

    logic          ld_en, sw_en, inc_en;
    logic [SW-1:0] ld_idx, ld_data, inc_idx;
    logic [SW-1:0] rb_idx;
    logic [SW-1:0] map_a, map_b, map_c;
    logic [CW-1:0] cnt_a, cnt_b;
    logic [CW-1:0] cnt_next;
    logic          over;
    logic          elig, better;

    wl_map_table #(.N(N), .SW(SW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .sw_en   (sw_en),
        .sw_a    (r_q.trig),
        .sw_b    (r_q.best),
        .ra_idx  (tr_addr[LA_W-1:OW]),
        .ra_data (map_a),
        .rb_idx  (rb_idx),
        .rb_data (map_b),
        .rc_idx  (r_q.idx),
        .rc_data (map_c)
    );

    wl_wear_counters #(.N(N), .SW(SW), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (inc_en),
        .inc_idx (inc_idx),
        .ra_idx  (map_b),
        .ra_cnt  (cnt_a),
        .rb_idx  (map_c),
        .rb_cnt  (cnt_b)
    );

    // Table read port b follows whichever logical sector the state works on.
    always_comb begin
        case (r_q.st)
            ST_IDLE: rb_idx = r_q.pend_sec;
            ST_WR_B: rb_idx = r_q.best;
            default: rb_idx = r_q.trig;
        endcase
    end

    // Post-increment count of the erased sector, held at the ceiling.
    assign cnt_next = (cnt_a == CNT_MAX) ? cnt_a : cnt_a + 1'b1;
    assign over     = cnt_next > cfg_threshold;
    assign elig     = cfg_pool[r_q.idx] && (r_q.idx != r_q.trig);
    assign better   = !r_q.found || (cnt_b < r_q.best_cnt);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.out_v = 1'b0;

        ld_en    = 1'b0;
        ld_idx   = r_q.idx;
        ld_data  = md_rdata;
        sw_en    = 1'b0;
        inc_en   = 1'b0;
        inc_idx  = map_b;
        md_req   = 1'b0;
        md_we    = 1'b0;
        md_addr  = r_q.idx;
        md_wdata = map_b;

        tr_ready = (r_q.st != ST_LOAD);
        er_ready = !r_q.pend_v;

        if (tr_valid && tr_ready) begin
            r_d.out_v    = 1'b1;
            r_d.out_addr = {1'b0, map_a, tr_addr[OW-1:0]};
        end

        case (r_q.st)
            ST_LOAD: begin
                md_req = 1'b1;
                if (md_ack) begin
                    ld_en = 1'b1;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.st  = ST_IDLE;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (r_q.pend_v) begin
                    r_d.pend_v = 1'b0;
                    inc_en     = 1'b1;
                    if (over && cfg_pool[r_q.pend_sec]) begin
                        r_d.st    = ST_SCAN;
                        r_d.trig  = r_q.pend_sec;
                        r_d.idx   = '0;
                        r_d.found = 1'b0;
                    end
                end
            end
            ST_SCAN: begin
                if (elig && better) begin
                    r_d.best     = r_q.idx;
                    r_d.best_cnt = cnt_b;
                    r_d.found    = 1'b1;
                end
                if (r_q.idx == LAST_IDX) begin
                    r_d.idx = '0;
                    r_d.st  = r_d.found ? ST_SWAP : ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_SWAP: begin
                sw_en  = 1'b1;
                r_d.st = ST_WR_A;
            end
            ST_WR_A: begin
                md_req  = 1'b1;
                md_we   = 1'b1;
                md_addr = r_q.trig;
                if (md_ack) begin
                    r_d.st = ST_WR_B;
                end
            end
            ST_WR_B: begin
                md_req  = 1'b1;
                md_we   = 1'b1;
                md_addr = r_q.best;
                if (md_ack) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (er_valid && er_ready) begin
            r_d.pend_v   = 1'b1;
            r_d.pend_sec = er_sector;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_LOAD;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == ST_LOAD);
    assign out_valid = r_q.out_v;
    assign out_addr  = r_q.out_addr;
    assign swap_done = r_q.done;
endmodule

// File: rtl/wl_remap_chk.sv
module wl_remap_chk #(
    parameter int N  = 16,
    parameter int OW = 8,
    parameter int CW = 8,
    localparam int SW   = $clog2(N),
    localparam int LA_W = SW + OW,
    localparam int PA_W = 1 + SW + OW
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    cfg_pool,
    input logic            busy,
    input logic            tr_valid,
    input logic            tr_ready,
    input logic            out_valid,
    input logic [PA_W-1:0] out_addr,
    input logic            er_valid,
    input logic            er_ready,
    input logic            md_req,
    input logic            md_we,
    input logic [SW-1:0]   md_addr,
    input logic            md_ack,
    input logic            swap_done
);
    assert_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tr_ready);

    assert_load_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && md_req) |-> !md_we);

    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(tr_valid && tr_ready));

    assert_user_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_addr[PA_W-1]);

    assert_pool_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (md_req && md_we) |-> cfg_pool[md_addr]);

    assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |-> $past(md_req && md_we && md_ack));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (md_req && !md_ack) |=> (md_req && $stable(md_addr) && $stable(md_we)));

    assert_slot_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (er_valid && er_ready) |=> !er_ready);
endmodule

bind wl_remap wl_remap_chk #(.N(N), .OW(OW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pool  (cfg_pool),
    .busy      (busy),
    .tr_valid  (tr_valid),
    .tr_ready  (tr_ready),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .er_valid  (er_valid),
    .er_ready  (er_ready),
    .md_req    (md_req),
    .md_we     (md_we),
    .md_addr   (md_addr),
    .md_ack    (md_ack),
    .swap_done (swap_done)
);

// File: tb/tb_wl_remap.sv
module tb_wl_remap;
    localparam int N    = 16;
    localparam int OW   = 8;
    localparam int CW   = 8;
    localparam int SW   = 4;
    localparam int LA_W = SW + OW;
    localparam int PA_W = 1 + SW + OW;
    localparam int CMAX = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   cfg_threshold = '0;
    logic [N-1:0]    cfg_pool = '0;
    logic            busy, tr_ready, out_valid, er_ready;
    logic            tr_valid = 1'b0;
    logic [LA_W-1:0] tr_addr = '0;
    logic [PA_W-1:0] out_addr;
    logic            er_valid = 1'b0;
    logic [SW-1:0]   er_sector = '0;
    logic            md_req, md_we, swap_done;
    logic [SW-1:0]   md_addr, md_wdata;
    logic            md_ack = 1'b0;
    logic [SW-1:0]   md_rdata = '0;

    always #10 clk = ~clk;

    wl_remap #(.N(N), .OW(OW), .CW(CW)) dut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_wr_cyc = -10;
    bit finished = 1'b0;

    logic [SW-1:0] md_mem [N];
    int rd_log [64];
    int rd_n = 0;
    int wr_a_log [256];
    int wr_d_log [256];
    int wr_n = 0;
    int done_n = 0;

    int mmap [N];
    int mcnt [N];
    int exp_a [256];
    int exp_d [256];
    int exp_n = 0;
    int exp_done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Metadata responder and write/done monitor (falling edge).
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            md_ack <= 1'b0;
        end else begin
            md_ack   <= md_req;
            md_rdata <= md_mem[md_addr];
            if (md_req && !md_we && rd_n < 64) begin
                rd_log[rd_n] = int'(md_addr);
                rd_n++;
            end
            if (md_req && md_we && wr_n < 256) begin
                wr_a_log[wr_n] = int'(md_addr);
                wr_d_log[wr_n] = int'(md_wdata);
                wr_n++;
                md_mem[md_addr] = md_wdata;
                last_wr_cyc = cyc;
            end
            if (swap_done) begin
                done_n++;
                chk(cyc == last_wr_cyc + 1, "R8", "done one cycle after 2nd write ack",
                    cyc - last_wr_cyc, 1);
            end
        end
    end

    // Bench model of one erase, written from the requirements.
    task automatic model_erase(input int l);
        int p;
        int best;
        p = mmap[l];
        if (mcnt[p] < CMAX) mcnt[p]++;
        if (mcnt[p] > int'(cfg_threshold) && cfg_pool[l]) begin
            best = -1;
            for (int j = 0; j < N; j++) begin
                if (cfg_pool[j] && j != l) begin
                    if (best < 0 || mcnt[mmap[j]] < mcnt[mmap[best]]) best = j;
                end
            end
            if (best >= 0) begin
                mmap[l] = mmap[best];
                mmap[best] = p;
                exp_a[exp_n] = l;    exp_d[exp_n] = mmap[l];    exp_n++;
                exp_a[exp_n] = best; exp_d[exp_n] = mmap[best]; exp_n++;
                exp_done++;
            end
        end
    endtask

    task automatic drive_erase(input int l);
        @(negedge clk);
        while (!er_ready) @(negedge clk);
        er_valid  = 1'b1;
        er_sector = SW'(l);
        @(posedge clk);
        @(negedge clk);
        er_valid = 1'b0;
        model_erase(l);
    endtask

    task automatic translate(input int l, input int off, input string req);
        logic [PA_W-1:0] exp;
        @(negedge clk);
        tr_valid = 1'b1;
        tr_addr  = {SW'(l), OW'(off)};
        @(posedge clk);
        @(negedge clk);
        tr_valid = 1'b0;
        exp = {1'b0, SW'(mmap[l]), OW'(off)};
        chk(out_valid == 1'b1, req, "out_valid after accept", int'(out_valid), 1);
        chk(out_addr == exp, req, $sformatf("translation of sector %0d", l),
            int'(out_addr), int'(exp));
        chk(out_addr[PA_W-1] == 1'b0, "R3", "region bit", int'(out_addr[PA_W-1]), 0);
    endtask

    task automatic settle_and_compare(input string req);
        repeat (N + 24) @(negedge clk);
        chk(done_n == exp_done, req, "swap_done pulse count", done_n, exp_done);
        chk(wr_n == exp_n, req, "metadata write count", wr_n, exp_n);
        for (int i = 0; i < exp_n && i < wr_n; i++) begin
            chk(wr_a_log[i] == exp_a[i], "R8", $sformatf("write %0d address", i),
                wr_a_log[i], exp_a[i]);
            chk(wr_d_log[i] == exp_d[i], "R8", $sformatf("write %0d data", i),
                wr_d_log[i], exp_d[i]);
        end
        for (int l = 0; l < N; l++) translate(l, (l * 37) & 8'hff, req);
    endtask

    task automatic t_reset_load();
        @(negedge clk);
        chk(busy == 1'b1, "R1", "busy during load", int'(busy), 1);
        chk(tr_ready == 1'b0, "R1", "tr_ready during load", int'(tr_ready), 0);
        for (int k = 0; k < 100 && busy; k++) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy drops after load", int'(busy), 0);
        chk(rd_n == N, "R1", "read count", rd_n, N);
        for (int i = 0; i < N && i < rd_n; i++)
            chk(rd_log[i] == i, "R1", $sformatf("read %0d address", i), rd_log[i], i);
    endtask

    task automatic t_translate();
        translate(0, 0, "R2");
        translate(5, 255, "R2");
        translate(15, 128, "R2");
        translate(9, 1, "R2");
    endtask

    task automatic t_threshold();
        cfg_threshold = 8'd3;
        cfg_pool      = 16'h3fff;
        // R4: three erases reach the threshold but do not exceed it
        for (int k = 0; k < 3; k++) drive_erase(2);
        settle_and_compare("R4");
        chk(done_n == 0, "R4", "no swap at threshold", done_n, 0);
        drive_erase(2);
        settle_and_compare("R4");
        chk(done_n == 1, "R4", "swap past threshold", done_n, 1);
    endtask

    task automatic t_tie();
        // R5: fresh sectors 9..11 tie at zero; lowest index is chosen
        cfg_threshold = 8'd0;
        cfg_pool      = 16'h0e00;
        drive_erase(9);
        settle_and_compare("R5");
        chk(wr_n >= 2 && wr_a_log[wr_n-1] == 10, "R5", "tie partner", wr_a_log[wr_n-1], 10);
    endtask

    task automatic t_no_partner();
        int d0;
        d0 = done_n;
        cfg_threshold = 8'd0;
        cfg_pool      = 16'h0008;
        drive_erase(3);
        settle_and_compare("R5");
        chk(done_n == d0, "R5", "lone pool sector gives no swap", done_n, d0);
    endtask

    task automatic t_retention();
        int p15;
        p15 = mmap[15];
        cfg_threshold = 8'd1;
        cfg_pool      = 16'h7fff;
        for (int k = 0; k < 4; k++) drive_erase(15);
        drive_erase(0);
        drive_erase(0);
        drive_erase(0);
        settle_and_compare("R6");
        chk(mmap[15] == p15, "R6", "model keeps retention entry", mmap[15], p15);
        translate(15, 77, "R6");
    endtask

    task automatic t_saturate();
        cfg_threshold = 8'd254;
        cfg_pool      = 16'h3fff;
        for (int k = 0; k < 300; k++) drive_erase(14);
        settle_and_compare("R7");
        cfg_pool = 16'h7fff;
        drive_erase(14);
        settle_and_compare("R7");
        chk(wr_n >= 2 && wr_a_log[wr_n-2] == 14, "R7", "saturated count triggers swap",
            wr_a_log[wr_n-2], 14);
    endtask

    task automatic t_pending();
        cfg_threshold = 8'd0;
        cfg_pool      = 16'h00f0;
        drive_erase(4);
        drive_erase(5);
        @(negedge clk);
        chk(er_ready == 1'b0, "R9", "slot full during swap", int'(er_ready), 0);
        settle_and_compare("R9");
        chk(er_ready == 1'b1, "R9", "slot free after drain", int'(er_ready), 1);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            md_mem[i] = SW'((i * 5 + 3) % N);
            mmap[i]   = (i * 5 + 3) % N;
            mcnt[i]   = 0;
        end
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        t_reset_load();
        t_translate();
        t_threshold();
        t_tie();
        t_no_partner();
        t_retention();
        t_saturate();
        t_pending();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule